// File: doc/BRIEF.md
# Synthesizer Divider Pair

This block holds the two programmable dividers of a frequency synthesizer loop. The feedback path counts qualifying cycles of a fast input, marked by a clock enable, and emits a one-cycle pulse every time a full 16-bit ratio of those enables has gone by. The reference path counts enables of a reference input. A fixed divide-by-4 prescaler feeds a programmable counter, so the overall reference ratio is four times the programmed count. Both pulse trains leave the block as buffered outputs, and they also drive the phase comparator downstream.

Ratios come from two holding registers. A serial loader outside the block presents a 16-bit word, a destination bit and a strobe. A holding register captures the word only on the clock where the strobe is first seen high. Each counter counts down and reloads from its holding register when it reaches zero. A new ratio therefore starts at the next terminal count and never shortens the period in progress. A programmed value below the legal minimum is treated as the minimum. All logic runs in one system clock domain, with a synchronous reset.

Top module: `synth_divider_pair`

## Requirements
- R1: While reset is high, and on the clock after it, both `fv_pulse` and `fr_pulse` are low. Reset sets the feedback ratio to 1056 and the reference count to 5. After reset, the first `fin_en` cycle gives a `fv_pulse`, and the fourth `xin_en` cycle gives a `fr_pulse`.
- R2: `fv_pulse` is high for exactly one clock, on the clock after the `fin_en` cycle that completes a period. Successive pulses are separated by exactly the effective feedback ratio in `fin_en` cycles.
- R3: `fr_pulse` is high for one clock, on the clock after the `xin_en` cycle that completes a period. Successive pulses are separated by 4 times the effective reference count in `xin_en` cycles.
- R4: A holding register is written only on the clock where `load_strobe` is high and was low on the clock before. Holding the strobe high, or changing `load_word` while the strobe is steady, leaves both ratios unchanged.
- R5: A load with `load_to_ref` = 0 stores `load_word[15:0]` as the feedback ratio.
- R6: A load with `load_to_ref` = 1 stores `load_word[15:2]` as the reference count. Bits 1:0 are ignored.
- R7: A ratio loaded during a period does not change that period. It governs the period that follows the next pulse.
- R8: A feedback ratio below 1056 acts as 1056.
- R9: A reference count below 5 acts as 5, which gives a reference ratio of 20.
- R10: In cycles without an enable, the matching counter and prescaler hold their state and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fin_en | input | 1 | One qualifying cycle of the feedback input |
| xin_en | input | 1 | One qualifying cycle of the reference input |
| load_strobe | input | 1 | Load request; its rising edge writes a holding register |
| load_to_ref | input | 1 | Load destination: 0 feedback ratio, 1 reference count |
| load_word | input | 16 | Word presented by the serial loader |
| fv_pulse | output | 1 | Feedback divider output pulse |
| fr_pulse | output | 1 | Reference divider output pulse |

## Verification
Every cycle, the embedded properties check the following:
- each output pulse lasts one clock and follows an enable;
- counters and the prescaler stay frozen when no enable arrives;
- holding registers move only on a strobe rising edge, and then take the right field;
- a reload never drops below the clamped floor.

Some behaviours only the bench scenarios can show, because they depend on whole periods:
- that the spacing between pulses equals the programmed ratio, with the factor of 4 on the reference path;
- that a mid-period load leaves the current period at its old length;
- that a too-small value yields periods of exactly 1056 or 20.

The bench mixes directed period measurements with a long random run of sparse enables and random loads, compared cycle by cycle against a period model.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
   // Returns the value that a counter actually reloads with.
   function automatic int unsigned floor_ratio(input int unsigned raw, input int unsigned lo);
      return (raw < lo) ? lo : raw;
   endfunction
endpackage

// File: rtl/div_load_ctrl.sv
module div_load_ctrl #(
   parameter int N_W     = 16,
   parameter int R_W     = 14,
   parameter int R_LSB   = 2,
   parameter int N_RST   = 1056,
   parameter int R_RST   = 5
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           strobe,
   input  logic           to_ref,
   input  logic [N_W-1:0] word,
   output logic [N_W-1:0] n_ratio,
   output logic [R_W-1:0] r_count
);
   localparam int R_MSB = R_LSB + R_W - 1;

   logic strobe_q;
   logic rise;
   logic [R_W-1:0] r_field;

   assign rise    = strobe && !strobe_q;
   assign r_field = word[R_MSB:R_LSB];

   always_ff @(posedge clk) begin
      if (rst) begin
         strobe_q <= 1'b0;
         n_ratio  <= N_W'(N_RST);
         r_count  <= R_W'(R_RST);
      end else begin
         strobe_q <= strobe;
         if (rise && !to_ref) n_ratio <= word;
         if (rise &&  to_ref) r_count <= r_field;
      end
   end

   AST_LOAD_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      !(strobe && !strobe_q) |=> ($stable(n_ratio) && $stable(r_count))); // R4
   AST_FB_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
      (strobe && !strobe_q && !to_ref) |=> (n_ratio == $past(word))); // R5
   AST_REF_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
      (strobe && !strobe_q && to_ref) |=> (r_count == $past(word[R_MSB:R_LSB]))); // R6
endmodule

// File: rtl/div_prescaler.sv
module div_prescaler #(
   parameter int LOG2 = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic en_in,
   output logic en_out
);
   generate
      if (LOG2 == 0) begin : g_bypass
         assign en_out = en_in;
      end else begin : g_count
         logic [LOG2-1:0] pc;
         always_ff @(posedge clk) begin
            if (rst)        pc <= '0;
            else if (en_in) pc <= pc + LOG2'(1);
         end
         assign en_out = en_in && (&pc);

         AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !en_in |=> $stable(pc)); // R10
      end
   endgenerate
endmodule

// File: rtl/div_counter.sv
module div_counter #(
   parameter int W   = 16,
   parameter int MIN = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] ratio,
   output logic         pulse
);
   import synth_div_pkg::*;

   localparam logic [W-1:0] MIN_V  = W'(MIN);
   localparam logic [W-1:0] MIN_M1 = W'(MIN - 1);
   localparam logic [W-1:0] ONE    = W'(1);

   logic [W-1:0] cnt;
   logic [W-1:0] eff;
   logic [W-1:0] reload;
   logic         term;

   assign eff    = W'(floor_ratio(int'(ratio), int'(MIN_V)));
   assign reload = eff - ONE;
   assign term   = (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= en && term;
         if (en) cnt <= term ? reload : (cnt - ONE);
      end
   end

   AST_PULSE_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
      pulse |-> $past(en)); // R2
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse); // R3
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt)); // R10
   AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
      (en && term) |=> (cnt >= MIN_M1)); // R8 R9
endmodule

// File: rtl/synth_divider_pair.sv
module synth_divider_pair #(
   parameter int N_W      = 16,
   parameter int R_CNT_W  = 14,
   parameter int PRE_LOG2 = 2,
   parameter int N_MIN    = 1056,
   parameter int R_MIN    = 5
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        fin_en,
   input  logic        xin_en,
   input  logic        load_strobe,
   input  logic        load_to_ref,
   input  logic [15:0] load_word,
   output logic        fv_pulse,
   output logic        fr_pulse
);
   localparam int WORD_W = 16;

   generate
      if (N_W != WORD_W) begin : g_bad_nw
         $error("feedback width must match the 16-bit load word");
      end
      if (R_CNT_W + PRE_LOG2 > WORD_W) begin : g_bad_rw
         $error("reference field does not fit in the load word");
      end
      if (N_MIN < 2 || R_MIN < 2) begin : g_bad_min
         $error("minimum ratios must be at least 2");
      end
   endgenerate

   logic [N_W-1:0]     n_ratio;
   logic [R_CNT_W-1:0] r_count;
   logic               pre_en;

   div_load_ctrl #(
      .N_W  (N_W),
      .R_W  (R_CNT_W),
      .R_LSB(PRE_LOG2),
      .N_RST(N_MIN),
      .R_RST(R_MIN)
   ) i_load (
      .clk    (clk),
      .rst    (rst),
      .strobe (load_strobe),
      .to_ref (load_to_ref),
      .word   (load_word),
      .n_ratio(n_ratio),
      .r_count(r_count)
   );

   div_counter #(.W(N_W), .MIN(N_MIN)) i_fb_cnt (
      .clk  (clk),
      .rst  (rst),
      .en   (fin_en),
      .ratio(n_ratio),
      .pulse(fv_pulse)
   );

   div_prescaler #(.LOG2(PRE_LOG2)) i_pre (
      .clk   (clk),
      .rst   (rst),
      .en_in (xin_en),
      .en_out(pre_en)
   );

   div_counter #(.W(R_CNT_W), .MIN(R_MIN)) i_ref_cnt (
      .clk  (clk),
      .rst  (rst),
      .en   (pre_en),
      .ratio(r_count),
      .pulse(fr_pulse)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!fv_pulse && !fr_pulse)); // R1
   AST_FR_AFTER_XIN: assert property (@(posedge clk) disable iff (rst)
      fr_pulse |-> $past(xin_en)); // R3
endmodule

// File: tb/test_synth_divider_pair.sv
module test_synth_divider_pair;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fin_en = 1'b0, xin_en = 1'b0;
   logic load_strobe = 1'b0, load_to_ref = 1'b0;
   logic [15:0] load_word = 16'd0;
   logic fv_pulse, fr_pulse;

   always #4 clk = ~clk;

   synth_divider_pair i_synth_divider_pair (
      .clk(clk), .rst(rst), .fin_en(fin_en), .xin_en(xin_en),
      .load_strobe(load_strobe), .load_to_ref(load_to_ref),
      .load_word(load_word), .fv_pulse(fv_pulse), .fr_pulse(fr_pulse)
   );

   int checks = 0, failures = 0;
   // model state
   int n_lat = 1056, r_lat = 5, n_rem = 0, r_rem = 3;
   bit prev_strb = 0, exp_fv = 0, exp_fr = 0;
   bit obs_fv, obs_fr;
   int fin_total = 0, fin_mark = 0, xin_total = 0, xin_mark = 0;
   int last_fv_period = 0, last_fr_period = 0, fv_seen = 0, fr_seen = 0;
   bit drv_rst = 1, drv_strb = 0, drv_sel = 0;
   logic [15:0] drv_word = 0;

   function automatic int n_eff(input int v); return (v < 1056) ? 1056 : v; endfunction
   function automatic int r_total(input int v); return 4 * ((v < 5) ? 5 : v); endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input bit fe, input bit xe);
      @(negedge clk);
      obs_fv = fv_pulse; obs_fr = fr_pulse;
      check("R2 fv_pulse", int'(obs_fv), int'(exp_fv));
      check("R3 fr_pulse", int'(obs_fr), int'(exp_fr));
      if (obs_fv) begin last_fv_period = fin_total - fin_mark; fin_mark = fin_total; fv_seen++; end
      if (obs_fr) begin last_fr_period = xin_total - xin_mark; xin_mark = xin_total; fr_seen++; end
      rst = drv_rst; fin_en = fe; xin_en = xe;
      load_strobe = drv_strb; load_to_ref = drv_sel; load_word = drv_word;
      exp_fv = 0; exp_fr = 0;
      if (drv_rst) begin
         n_lat = 1056; r_lat = 5; n_rem = 0; r_rem = 3; prev_strb = 0;
         fin_mark = fin_total; xin_mark = xin_total;
      end else begin
         if (fe) begin
            fin_total++;
            if (n_rem == 0) begin exp_fv = 1; n_rem = n_eff(n_lat) - 1; end
            else n_rem--;
         end
         if (xe) begin
            xin_total++;
            if (r_rem == 0) begin exp_fr = 1; r_rem = r_total(r_lat) - 1; end
            else r_rem--;
         end
         if (drv_strb && !prev_strb) begin
            if (drv_sel) r_lat = int'(drv_word[15:2]);
            else         n_lat = int'(drv_word);
         end
         prev_strb = drv_strb;
      end
   endtask

   task automatic load(input bit sel, input int value);
      drv_sel = sel; drv_word = 16'(value); drv_strb = 1;
      step(0, 0);
      drv_strb = 0;
      step(0, 0);
   endtask

   task automatic run_fv(input int pulses);
      int target = fv_seen + pulses;
      while (fv_seen < target) step(1, 0);
   endtask

   task automatic run_fr(input int pulses);
      int target = fr_seen + pulses;
      while (fr_seen < target) step(0, 1);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state and first pulses
      drv_rst = 1;
      repeat (3) step(1, 1);
      check("R1 fv low in reset", int'(obs_fv), 0);
      check("R1 fr low in reset", int'(obs_fr), 0);
      drv_rst = 0;
      step(0, 0);
      check("R1 fv low after reset", int'(obs_fv), 0);
      step(1, 1);
      step(0, 1);
      check("R1 first fin_en pulses", int'(obs_fv), 1);
      step(0, 1);
      step(0, 1);
      check("R1 no fr before 4th", int'(obs_fr), 0);
      step(0, 0);
      check("R1 fr at 4th xin_en", int'(obs_fr), 1);
      run_fv(2);
      check("R1 default feedback period", last_fv_period, 1056);
      run_fr(2);
      check("R1 default reference period", last_fr_period, 20);

      // R5: feedback load
      load(0, 1100);
      run_fv(2);
      check("R5 feedback period", last_fv_period, 1100);

      // R4: strobe held high, word changes ignored
      drv_sel = 0; drv_word = 16'd1200; drv_strb = 1;
      step(0, 0);
      drv_word = 16'd1300;
      run_fv(3);
      check("R4 held strobe keeps ratio", last_fv_period, 1200);
      drv_sel = 1; drv_word = 16'd40;
      run_fv(1);
      check("R4 held strobe ignores sel", last_fv_period, 1200);
      drv_strb = 0;
      step(0, 0);

      // R8: clamp below minimum
      load(0, 50);
      run_fv(2);
      check("R8 clamped feedback", last_fv_period, 1056);

      // R7: mid-period load
      repeat (300) step(1, 0);
      load(0, 1111);
      run_fv(1);
      check("R7 current period kept", last_fv_period, 1056);
      run_fv(1);
      check("R7 new period next", last_fv_period, 1111);

      // R6: reference field, low bits ignored
      load(1, (7 << 2) | 3);
      run_fr(2);
      check("R6 reference period", last_fr_period, 28);
      // R9: clamp reference
      load(1, (2 << 2) | 1);
      run_fr(2);
      check("R9 clamped reference", last_fr_period, 20);

      // R10: no enables, no pulses
      for (int i = 0; i < 40; i++) begin
         step(0, 0);
         check("R10 idle fv", int'(obs_fv), 0);
         check("R10 idle fr", int'(obs_fr), 0);
      end

      // random phase, per-cycle model comparison (R2 R3 R4 R5 R6 R7)
      for (int i = 0; i < 60000; i++) begin
         if ($urandom_range(0, 99) < 2) begin
            drv_strb = !drv_strb;
            drv_sel  = $urandom_range(0, 1) == 1;
            drv_word = drv_sel ? 16'(($urandom_range(0, 12) << 2) | $urandom_range(0, 3))
                               : 16'($urandom_range(1000, 1150));
         end else if ($urandom_range(0, 9) == 0) begin
            drv_word = 16'($urandom);
         end
         step($urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1);
      end
      drv_strb = 0;
      step(0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule